// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the management-bus master of an Ethernet MAC. It turns one 32-bit word written by software into a complete clause-22 management frame on the MDC/MDIO pins. Every frame begins with 32 preamble bits of one. After the preamble the 32 bits of the word go out, most significant bit first. Software builds the whole frame itself: start bits, opcode, PHY address, register number, turnaround and data. The block does not check or rebuild any of these fields. It looks only at the opcode, to tell whether the PHY drives the tail of the frame.

For a read, the block stops driving MDIO for the two turnaround bits and the 16 data bits. It samples the PHY's answer on each rising MDC edge and writes those bits into the low half of the same frame register. When the last bit ends, a sticky completion flag is set. Software clears the flag by writing a one to it. A speed register sets the MDC half-period in system clocks, so software can keep MDC at or below 2.5 MHz. A status bit shows that a frame is in flight. While that bit is set, writes to the frame and speed registers are dropped.

The register bus is a simple synchronous write port with a combinational read mux. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, MDC, MDIO output and MDIO output enable are low. The completion flag and busy bit read 0, and the speed register reads its default of 20.
- R2: A frame is 64 MDC periods long: 32 ones, then the frame word from bit 31 down to bit 0. A frame starts with MDC low, and MDIO output changes only while MDC goes low.
- R3: MDC stays low while idle. While a frame runs, each MDC half-period lasts exactly S system clocks, where S is the speed register (address 1, bits 6:1). Bit 0 of that register always reads 0 and has no effect on S.
- R4: A frame whose bits 29:28 are 10 is a read. The output enable drops for the last 18 bit periods. On each rising MDC edge of the last 16 periods, MDIO input is stored into frame register bits 15:0, MSB first, and bits 31:16 keep their value. An idle line pulled high therefore reads as 0xFFFF.
- R5: For any other opcode, the output enable stays high for all 64 periods and MDIO carries the word unchanged. The frame register keeps the written word.
- R6: Bit 23 of the event register (address 2) is set on the clock edge where the frame ends. Writing a 1 to bit 23 clears it, and writing a 0 there leaves it unchanged.
- R7: Bit 0 of the status register (address 3) reads 1 from the edge that accepts a frame-register write (address 0) until the frame ends.
- R8: A write to the frame register while busy is ignored. The running frame and the register contents are not disturbed.
- R9: A write to the speed register while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register index: 0 frame, 1 speed, 2 event, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen on the pin |

## Verification
The hardest situation to reach is a register write that lands in the middle of a read frame. A write to the frame register or the speed register that arrives while the PHY is answering must leave the pins and the captured data unchanged. The bench starts a read frame without waiting for it to end. While the frame runs, it polls status and issues both ignored writes. A reference model checks MDC, MDIO and the enable on every clock, and the same model plays the PHY, driving answer bits only in the 16 data periods and toggling the line elsewhere. A second read uses a line held high to give 0xFFFF. Two speeds are used, one of them written with bit 0 set, to show the half-period timing.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_W  = 32;
  localparam int PREAMBLE = 32;
  localparam int REPLY_W  = 16;
  localparam int TURN_W   = 2;
  localparam int EVT_POS  = 23;

  typedef enum logic [1:0] {
    REG_FRAME  = 2'd0,
    REG_SPEED  = 2'd1,
    REG_EVENT  = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  localparam logic [1:0] OPC_READ = 2'b10;
endpackage

// File: rtl/mdc_tick_gen.sv
module mdc_tick_gen #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (half != '0) && (cnt_q == half - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    if (!run || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int DATA_W   = 32,
  parameter int PRE_BITS = 32,
  parameter int RD_BITS  = 16,
  parameter int TA_BITS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] start_word,
  input  logic              tick,
  input  logic              mdio_in,
  output logic              busy,
  output logic              done,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] word
);
  localparam int TOTAL = PRE_BITS + DATA_W;
  localparam int BIT_W = $clog2(TOTAL);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(TOTAL - 1);
  localparam logic [BIT_W-1:0] PRE_END   = BIT_W'(PRE_BITS);
  localparam logic [BIT_W-1:0] REL_FIRST = BIT_W'(TOTAL - RD_BITS - TA_BITS);
  localparam logic [BIT_W-1:0] SMP_FIRST = BIT_W'(TOTAL - RD_BITS);
  localparam int OP_HI = DATA_W - 3;
  localparam int OP_LO = DATA_W - 4;

  logic              busy_q, busy_d;
  logic              mdc_q, mdc_d;
  logic [BIT_W-1:0]  bitn_q, bitn_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic [IDX_W-1:0]  idx;
  logic              is_read, release_line;

  assign idx          = IDX_W'(LAST_BIT - bitn_q);
  assign is_read      = (word_q[OP_HI:OP_LO] == mdio_mgmt_pkg::OPC_READ);
  assign release_line = is_read && (bitn_q >= REL_FIRST);

  // next state
  always_comb begin
    busy_d = busy_q;
    mdc_d  = mdc_q;
    bitn_d = bitn_q;
    word_d = word_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      mdc_d  = 1'b0;
      bitn_d = '0;
      word_d = start_word;
    end else if (busy_q && tick) begin
      if (!mdc_q) begin
        mdc_d = 1'b1;
        if (is_read && (bitn_q >= SMP_FIRST)) word_d[idx] = mdio_in;
      end else begin
        mdc_d = 1'b0;
        if (bitn_q == LAST_BIT) busy_d = 1'b0;
        else                    bitn_d = bitn_q + BIT_W'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      bitn_q <= '0;
      word_q <= '0;
    end else begin
      busy_q <= busy_d;
      mdc_q  <= mdc_d;
      bitn_q <= bitn_d;
      word_q <= word_d;
    end
  end

  assign busy     = busy_q;
  assign done     = busy_q && tick && mdc_q && (bitn_q == LAST_BIT);
  assign mdc      = mdc_q;
  assign mdio_oe  = busy_q && !release_line;
  assign mdio_out = mdio_oe && ((bitn_q < PRE_END) ? 1'b1 : word_q[idx]);
  assign word     = word_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int SPD_W     = 6,
  parameter int DEF_SPEED = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  import mdio_mgmt_pkg::*;

  localparam int SPD_REG_W = SPD_W + 1;

  logic                 rst_meta, rst_q;
  logic [SPD_REG_W-1:0] speed_q, speed_d;
  logic                 evt_q, evt_d;
  logic                 busy, done, tick;
  logic [FRAME_W-1:0]   frame_word;
  logic                 wr_frame, wr_speed, wr_event, speed_en;
  reg_sel_e             sel;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_frame = bus_sel && bus_wr && (sel == REG_FRAME) && !busy;
  assign wr_speed = bus_sel && bus_wr && (sel == REG_SPEED);
  assign wr_event = bus_sel && bus_wr && (sel == REG_EVENT) && bus_wdata[EVT_POS];
  assign speed_en = wr_speed && !busy;

  always_comb begin
    speed_d = {bus_wdata[SPD_W:1], 1'b0};
    evt_d   = evt_q;
    if (wr_event) evt_d = 1'b0;
    if (done)     evt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      speed_q <= SPD_REG_W'(DEF_SPEED);
      evt_q   <= 1'b0;
    end else begin
      if (speed_en) speed_q <= speed_d;
      evt_q <= evt_d;
    end
  end

  mdc_tick_gen #(.CNT_W(SPD_REG_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_q),
    .run   (busy),
    .half  (speed_q),
    .tick  (tick)
  );

  mdio_frame_engine #(
    .DATA_W   (FRAME_W),
    .PRE_BITS (PREAMBLE),
    .RD_BITS  (REPLY_W),
    .TA_BITS  (TURN_W)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_q),
    .start      (wr_frame),
    .start_word (bus_wdata),
    .tick       (tick),
    .mdio_in    (mdio_in),
    .busy       (busy),
    .done       (done),
    .mdc        (mdc),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe),
    .word       (frame_word)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      REG_FRAME:  bus_rdata = frame_word;
      REG_SPEED:  bus_rdata = 32'(speed_q);
      REG_EVENT:  bus_rdata[EVT_POS] = evt_q;
      REG_STATUS: bus_rdata[0] = busy;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int DATA_W = 32,
  parameter int SPD_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mdc,
  input logic              mdio_out,
  input logic              mdio_oe,
  input logic              evt,
  input logic [DATA_W-1:0] word,
  input logic [SPD_W:0]    speed
);
  assert_mdc_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_frame_starts_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mdc);

  assert_pins_hold_high_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  assert_event_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> evt);

  assert_frame_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(word[DATA_W-1:16]));

  assert_speed_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(speed));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.DATA_W(32), .SPD_W(SPD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .busy     (busy),
  .mdc      (mdc),
  .mdio_out (mdio_out),
  .mdio_oe  (mdio_oe),
  .evt      (evt_q),
  .word     (frame_word),
  .speed    (speed_q)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit live = 0, arm = 0, mact = 0, mrd = 0;
  int j = 0, mS = 20;
  logic [31:0] mword;
  logic [15:0] mreply;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model of the pins and the answering PHY, stepped every clock
  always @(negedge clk) begin
    if (arm) begin mact = 1; j = 0; arm = 0; end
    if (live && mact && j == 128 * mS) begin
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R2 end of frame", {mdc, mdio_oe}, 0);
      mact = 0;
    end else if (live && mact) begin
      int b, p;
      bit e_mdc, e_oe, e_out;
      b = j / (2 * mS);
      p = 63 - b;
      e_mdc = ((j / mS) % 2) == 1;
      e_oe  = !(mrd && b >= 46);
      e_out = e_oe && ((b < 32) ? 1'b1 : mword[p]);
      check(mdc == e_mdc, "R3 mdc", 32'(mdc), 32'(e_mdc));
      check(mdio_oe == e_oe, mrd ? "R4 oe" : "R5 oe", 32'(mdio_oe), 32'(e_oe));
      check(mdio_out == e_out, "R2 mdio_out", 32'(mdio_out), 32'(e_out));
      mdio_in = (b >= 48) ? mreply[63 - b] : ((j % 2) == 1);
      j++;
    end else if (live) begin
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R3 idle pins", {mdc, mdio_oe}, 0);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic start_frame(input logic [31:0] w, input logic [15:0] reply, input int s);
    mword = w; mreply = reply; mS = s; mrd = (w[29:28] == 2'b10);
    wr(2'd0, w);
    arm = 1;
  endtask

  task automatic wait_end();
    wait (arm == 0 && mact == 0);
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, w;
    repeat (3) @(posedge clk);
    // R1 during reset
    check(mdc == 0 && mdio_oe == 0 && mdio_out == 0, "R1 pins in reset", {mdc, mdio_oe, mdio_out}, 0);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    live = 1;
    rd(2'd1, d); check(d == 32'd20, "R1 speed default", d, 32'd20);
    rd(2'd2, d); check(d == 0, "R1 event clear", d, 0);
    rd(2'd3, d); check(d == 0, "R1 not busy", d, 0);
    rd(2'd0, d); check(d == 0, "R1 frame reg", d, 0);

    // write frame at default speed (R5, R6, R7)
    w = 32'h5002_0000 | (32'd3 << 23) | (32'd5 << 18) | 32'hA5C3;
    start_frame(w, 16'h0, 20);
    rd(2'd3, d); check(d == 1, "R7 busy during write frame", d, 1);
    wait_end();
    rd(2'd3, d); check(d == 0, "R7 idle after frame", d, 0);
    rd(2'd2, d); check(d == (32'd1 << 23), "R6 event set", d, 32'd1 << 23);
    rd(2'd0, d); check(d == w, "R5 word kept", d, w);
    wr(2'd2, 32'h0);
    rd(2'd2, d); check(d == (32'd1 << 23), "R6 write 0 keeps event", d, 32'd1 << 23);
    wr(2'd2, 32'd1 << 23);
    rd(2'd2, d); check(d == 0, "R6 write 1 clears event", d, 0);

    // speed with bit 0 set (R3)
    wr(2'd1, 32'd5);
    rd(2'd1, d); check(d == 32'd4, "R3 speed bit0 dropped", d, 32'd4);

    // read frame with mid-frame writes (R4, R7, R8, R9)
    w = 32'h6002_0000 | (32'd31 << 23) | (32'd2 << 18) | 32'h0000_BEEF;
    start_frame(w, 16'h1378, 4);
    repeat (40) @(posedge clk);
    rd(2'd3, d); check(d == 1, "R7 busy during read frame", d, 1);
    wr(2'd0, 32'h5FFF_FFFF);
    wr(2'd1, 32'd8);
    rd(2'd1, d); check(d == 32'd4, "R9 speed write ignored", d, 32'd4);
    repeat (300) @(posedge clk);
    wr(2'd0, 32'h5000_0000);
    wait_end();
    rd(2'd0, d); check(d == {w[31:16], 16'h1378}, "R4 R8 read result", d, {w[31:16], 16'h1378});
    rd(2'd2, d); check(d == (32'd1 << 23), "R6 event after read", d, 32'd1 << 23);

    // read with nobody answering: line high gives all ones (R4)
    wr(2'd1, 32'd2);
    w = 32'h6002_0000 | (32'd7 << 23) | (32'd1 << 18);
    start_frame(w, 16'hFFFF, 2);
    wait_end();
    rd(2'd0, d); check(d[15:0] == 16'hFFFF, "R4 no PHY reads ones", d, {w[31:16], 16'hFFFF});

    // back-to-back write frame with zero data (R5)
    w = 32'h5002_0000 | (32'd1 << 23) | (32'd0 << 18);
    start_frame(w, 16'h0, 2);
    wait_end();
    rd(2'd0, d); check(d == w, "R5 zero data word kept", d, w);
    repeat (10) @(posedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule